// File: doc/BRIEF.md
# Single-Wire Multi-Master Bus Transmitter

This block is the sending and arbitration half of one node on a shared one-wire bus. A resistor holds the line high, and every node can only pull it low or let it go, so the line behaves as a wired-AND. The block first collects a frame of bytes from a valid/ready stream into a small local buffer. It then waits until the line has stayed high for a quiet period that depends on the node's priority. It claims the line with a short low-then-high verify pulse followed by a long takeover low, and then sends the frame as return-to-zero bit slots.

Every level the block drives is compared with the level it reads back through a synchronizer. If it has let the line go but reads it low, another node has taken the line. The block then releases at once, pulses a lost flag and goes back to waiting for a quiet line. The frame stays in the buffer and is sent again from its first bit on the next attempt. When the last slot ends, the block pulses a done flag and is ready for a new frame. Receive decoding belongs to another block.

Top module: `swire_tx`

## Requirements
- R1: After reset, line_pull_o is 0, in_ready is 1, and sent_o and lost_o are 0. line_pull_o=1 means pull the line low and 0 means release it.
- R2: A claim starts only after the synchronized line has read high for W = IDLE_BASE + prio_i*PRIO_STEP clocks in a row, and any low reading restarts the count. On a quiet line, line_pull_o rises after the W-th rising edge that follows the edge accepting the final byte. If the line was low, line_pull_o rises after the (W+SYNC_STAGES)-th edge after the line goes back high.
- R3: A larger prio_i gives a longer quiet wait, PRIO_STEP clocks per step, so prio_i=0 claims first.
- R4: The claim drives the line low for GAP_CLKS clocks, releases it for GAP_CLKS clocks, and then drives it low for TAKE_CLKS clocks.
- R5: Each bit takes SLOT_CLKS clocks and starts low. A 1 stays low for SLOT_CLKS/4 clocks and a 0 for 3*SLOT_CLKS/4 clocks, and the line is released for the rest of the slot.
- R6: Bytes go out in the order they were accepted, and each byte is sent most significant bit first.
- R7: in_ready is high only while a frame is being collected. The frame ends with the byte that has in_last=1, or with the MAX_BYTES-th byte if in_last has not come by then.
- R8: sent_o pulses for one clock in the clock right after the last slot ends. In that same clock the line is released and in_ready is high again.
- R9: During the claim and the data phase, the synchronized line is compared with the drive level from SYNC_STAGES clocks earlier. If the block has released the line but reads it low, line_pull_o drops and lost_o pulses for one clock, SYNC_STAGES+1 clocks after the line was pulled low.
- R10: After a loss, the block waits for a quiet line again and then sends the same frame from its first bit.
- R11: A low line seen while waiting for a quiet line only restarts the wait and never raises lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_i | input | PRIO_W | Priority step; a larger value waits longer |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts a byte |
| line_i | input | 1 | Raw bus level, not synchronized |
| line_pull_o | output | 1 | 1 pulls the bus low, 0 releases it |
| sent_o | output | 1 | One-clock pulse when a frame has been sent |
| lost_o | output | 1 | One-clock pulse when arbitration is lost |

## Verification
On a quiet line, the first pull is due W+1 clocks after the handshake edge of the final byte, measured at the falling edge. If another node was holding the line low, it is due W+2 falling edges after that node lets go. Once the first pull is seen, each later clock's level is predicted from slot arithmetic, and sent_o is expected exactly frame-length clocks later. Collisions are injected at a falling edge while the block is releasing the line. lost_o and the release are expected exactly three clocks later, and the two cycles in between must still follow the normal schedule.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_LOAD = 3'd0,
        ST_IDLE = 3'd1,
        ST_VLO  = 3'd2,
        ST_VHI  = 3'd3,
        ST_TAKE = 3'd4,
        ST_DATA = 3'd5
    } tx_state_e;

    // Return-to-zero shape: a one is a short low, a zero is a long low.
    function automatic logic rz_low(input logic bit_v, input int unsigned pos,
                                    input int unsigned slot);
        int unsigned lim;
        lim = bit_v ? (slot / 4) : ((3 * slot) / 4);
        return pos < lim;
    endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q, ff_d;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    // Resets to the released (high) level so the line reads idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/swire_frame_buf.sv
module swire_frame_buf
    import swire_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [AW-1:0]           waddr_i,
    input  logic [BYTE_W-1:0]       wdata_i,
    output logic [DEPTH*BYTE_W-1:0] flat_o
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat_o[g*BYTE_W +: BYTE_W] = mem_q[g];
    end
endmodule

// File: rtl/swire_tx.sv
module swire_tx
    import swire_pkg::*;
#(
    parameter int SLOT_CLKS   = 16,
    parameter int GAP_CLKS    = 4,
    parameter int TAKE_CLKS   = 48,
    parameter int IDLE_BASE   = 64,
    parameter int PRIO_STEP   = 16,
    parameter int PRIO_W      = 3,
    parameter int MAX_BYTES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              line_i,
    output logic              line_pull_o,
    output logic              sent_o,
    output logic              lost_o
);
    localparam int IDX_W    = $clog2(MAX_BYTES);
    localparam int BIT_W    = IDX_W + 3;
    localparam int WAIT_MAX = IDLE_BASE + ((1 << PRIO_W) - 1) * PRIO_STEP;
    localparam int CNT_W    = $clog2(WAIT_MAX + TAKE_CLKS + SLOT_CLKS + GAP_CLKS + 1);

    typedef struct packed {
        tx_state_e              state;
        logic [CNT_W-1:0]       cnt;
        logic [BIT_W-1:0]       bitn;
        logic [IDX_W-1:0]       wr;
        logic [IDX_W-1:0]       last_idx;
        logic                   drive;
        logic [SYNC_STAGES-1:0] dly;
        logic                   done;
        logic                   lost;
    } regs_t;

    regs_t r_q, r_d;

    logic                          line_s;
    logic                          wr_en;
    logic [MAX_BYTES*BYTE_W-1:0]   frame_flat;
    logic [CNT_W-1:0]              wait_last;
    logic [BIT_W-1:0]              last_bit;
    logic                          active;
    logic                          mismatch;

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    assign wr_en = in_valid && (r_q.state == ST_LOAD);

    swire_frame_buf #(.DEPTH(MAX_BYTES)) u_buf (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (r_q.wr),
        .wdata_i (in_data),
        .flat_o  (frame_flat)
    );

    assign wait_last = CNT_W'(IDLE_BASE - 1) + CNT_W'(prio_i) * CNT_W'(PRIO_STEP);
    assign last_bit  = {r_q.last_idx, 3'b111};
    assign active    = (r_q.state == ST_VLO) || (r_q.state == ST_VHI) ||
                       (r_q.state == ST_TAKE) || (r_q.state == ST_DATA);
    // Released earlier (dly=0) but reading low, or pulling but reading high.
    assign mismatch  = active && (line_s == r_q.dly[SYNC_STAGES-1]);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.lost = 1'b0;
        r_d.dly  = {r_q.dly[SYNC_STAGES-2:0], r_q.drive};

        case (r_q.state)
            ST_LOAD: begin
                if (in_valid) begin
                    if (in_last || r_q.wr == IDX_W'(MAX_BYTES - 1)) begin
                        r_d.last_idx = r_q.wr;
                        r_d.wr       = '0;
                        r_d.state    = ST_IDLE;
                        r_d.cnt      = '0;
                    end else begin
                        r_d.wr = r_q.wr + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (!line_s) begin
                    r_d.cnt = '0;
                end else if (r_q.cnt == wait_last) begin
                    r_d.state = ST_VLO;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_VLO: begin
                if (r_q.cnt == CNT_W'(GAP_CLKS - 1)) begin
                    r_d.state = ST_VHI;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_VHI: begin
                if (r_q.cnt == CNT_W'(GAP_CLKS - 1)) begin
                    r_d.state = ST_TAKE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TAKE: begin
                if (r_q.cnt == CNT_W'(TAKE_CLKS - 1)) begin
                    r_d.state = ST_DATA;
                    r_d.cnt   = '0;
                    r_d.bitn  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (r_q.cnt == CNT_W'(SLOT_CLKS - 1)) begin
                    r_d.cnt = '0;
                    if (r_q.bitn == last_bit) begin
                        r_d.state = ST_LOAD;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.bitn = r_q.bitn + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_LOAD;
        endcase

        if (mismatch) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.bitn  = '0;
            r_d.lost  = 1'b1;
        end

        // Drive level is decoded from the next position, so the pin is a flop.
        r_d.drive = (r_d.state == ST_VLO) || (r_d.state == ST_TAKE) ||
                    ((r_d.state == ST_DATA) &&
                     rz_low(frame_flat[{r_d.bitn[BIT_W-1:3], ~r_d.bitn[2:0]}],
                            32'(r_d.cnt), SLOT_CLKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready    = (r_q.state == ST_LOAD);
    assign line_pull_o = r_q.drive;
    assign sent_o      = r_q.done;
    assign lost_o      = r_q.lost;

    // R7: the byte that closes a frame is followed by a busy cycle
    assert_frame_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_last || r_q.wr == IDX_W'(MAX_BYTES - 1)))
        |=> !in_ready);

    // R9: a readback mismatch releases the line and flags the loss next cycle
    assert_loss_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (lost_o && !line_pull_o));

    // R2: the verify pulse only starts after a high synchronized reading
    assert_claim_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_VLO && $past(r_q.state) == ST_IDLE) |-> $past(line_s));

    // R8: completion leaves the line released and input open again
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sent_o |-> (!line_pull_o && in_ready && !lost_o));

    // R11: no loss is flagged from the quiet-wait state
    assert_idle_no_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !lost_o) |=> (!lost_o || $past(active)));
endmodule

// File: tb/sim_swire_tx.sv
`timescale 1ns/1ps
module sim_swire_tx;
    localparam int SLOT = 8;
    localparam int GAP  = 4;
    localparam int TAKE = 16;
    localparam int IB   = 16;
    localparam int PS   = 8;
    localparam int PW   = 2;
    localparam int MB   = 4;
    localparam int BASE = 2 * GAP + TAKE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] prio = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          line_pull_o;
    logic          sent_o;
    logic          lost_o;
    logic          other_low = 1'b0;
    logic          line;

    int total = 0;
    int bad = 0;
    logic [7:0] fb [MB];
    int fn = 1;
    int fi, fa, fe;
    bit saw_lost;

    always #2 clk = ~clk;
    assign line = ~(line_pull_o | other_low);

    swire_tx #(
        .SLOT_CLKS(SLOT), .GAP_CLKS(GAP), .TAKE_CLKS(TAKE), .IDLE_BASE(IB),
        .PRIO_STEP(PS), .PRIO_W(PW), .MAX_BYTES(MB), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .prio_i(prio), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .line_i(line), .line_pull_o(line_pull_o), .sent_o(sent_o), .lost_o(lost_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int frame_len();
        return BASE + fn * 8 * SLOT;
    endfunction

    function automatic int exp_low(input int i);
        int b, t, lim;
        logic [7:0] byt;
        if (i < GAP) return 1;
        if (i < 2 * GAP) return 0;
        if (i < BASE) return 1;
        b = (i - BASE) / SLOT;
        t = (i - BASE) % SLOT;
        byt = fb[b / 8];
        lim = byt[7 - (b % 8)] ? SLOT / 4 : (3 * SLOT) / 4;
        return (t < lim) ? 1 : 0;
    endfunction

    task automatic send_frame(input int n, input bit tag_last);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[k];
            in_last  = tag_last && (k == n - 1);
            @(posedge clk);
        end
        fn = n;
    endtask

    task automatic wait_rise(output int c);
        c = 0;
        do begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (lost_o) saw_lost = 1'b1;
            c++;
        end while (!line_pull_o && c < 3000);
    endtask

    // Index 0 is the negedge where the first pull was seen.
    task automatic scan_wave(input int from, input int to, inout int errs);
        int el, ed;
        for (int i = from; i <= to; i++) begin
            if (i != from) @(negedge clk);
            el = (i < frame_len()) ? exp_low(i) : 0;
            ed = (i == frame_len()) ? 1 : 0;
            if (line_pull_o !== el[0] || sent_o !== ed[0] || lost_o !== 1'b0) begin
                if (errs == 0) begin
                    fi = i; fa = {sent_o, line_pull_o}; fe = {ed[0], el[0]};
                end
                errs++;
            end
        end
    endtask

    task automatic full_frame(input string req);
        int errs = 0;
        scan_wave(0, frame_len(), errs);
        check(errs == 0, req, $sformatf("waveform {sent,pull} at index %0d", fi), fa, fe);
        check(in_ready == 1'b1, "R8", "in_ready with sent pulse", in_ready, 1);
    endtask

    task automatic collide(input int inj, input int hold);
        int errs = 0;
        int c;
        int w;
        w = IB + PS * int'(prio);
        scan_wave(0, inj, errs);
        other_low = 1'b1;
        @(negedge clk);
        scan_wave(inj + 1, inj + 2, errs);
        check(errs == 0, "R4 R5", $sformatf("pre-loss schedule index %0d", fi), fa, fe);
        @(negedge clk);
        check(lost_o == 1'b1, "R9", "lost pulse 3 clocks after collision", lost_o, 1);
        check(line_pull_o == 1'b0, "R9", "release on loss", line_pull_o, 0);
        @(negedge clk);
        check(lost_o == 1'b0, "R9", "lost pulse one clock wide", lost_o, 0);
        repeat (hold) @(negedge clk);
        other_low = 1'b0;
        wait_rise(c);
        check(c == w + 2, "R10", "retry claim delay after line returns", c, w + 2);
        full_frame("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, w;
        repeat (3) @(negedge clk);
        check(line_pull_o == 1'b0, "R1", "reset pull", line_pull_o, 0);
        check(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
        check(sent_o == 1'b0, "R1", "reset sent", sent_o, 0);
        check(lost_o == 1'b0, "R1", "reset lost", lost_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h81; fb[3] = 8'h7E;
        // R2 R3: priority sweep with frames of 1..4 bytes
        for (int p = 0; p < 4; p++) begin
            prio = PW'(p);
            w = IB + PS * p;
            send_frame(p + 1, 1'b1);
            wait_rise(c);
            check(c == w + 1, "R3", $sformatf("quiet wait at prio %0d", p), c, w + 1);
            check(in_ready == 1'b0, "R7", "ready low during transfer", in_ready, 0);
            full_frame("R4 R5 R6 R8");
        end

        // R7: a frame of MAX_BYTES without in_last closes itself
        prio = '0;
        fb[0] = 8'h01; fb[1] = 8'hFE; fb[2] = 8'h55; fb[3] = 8'hC3;
        send_frame(MB, 1'b0);
        wait_rise(c);
        check(c == IB + 1, "R7", "claim after full buffer", c, IB + 1);
        full_frame("R7");

        // R2 R11: another node pulls during the quiet wait
        prio = 2'd1;
        w = IB + PS;
        saw_lost = 1'b0;
        send_frame(2, 1'b1);
        repeat (5) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
        end
        other_low = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (lost_o) saw_lost = 1'b1;
        end
        other_low = 1'b0;
        wait_rise(c);
        check(c == w + 2, "R2", "quiet wait restarted by low line", c, w + 2);
        check(saw_lost == 1'b0, "R11", "no loss during quiet wait", saw_lost, 0);
        full_frame("R2");

        // R9 R10: collision in the released half of the verify pulse
        send_frame(3, 1'b1);
        wait_rise(c);
        check(c == w + 1, "R2", "claim before collision", c, w + 1);
        collide(GAP, 10);

        // R9 R10: collision in the released tail of the first data bit (a zero)
        prio = '0;
        fb[0] = 8'h00; fb[1] = 8'h9A;
        send_frame(2, 1'b1);
        wait_rise(c);
        check(c == IB + 1, "R2", "claim before data collision", c, IB + 1);
        collide(BASE + (3 * SLOT) / 4, 7);

        // R5 R6: every byte value, four per frame, priorities rotating
        for (int v = 0; v < 256; v += 4) begin
            prio = PW'((v / 4) % 4);
            w = IB + PS * ((v / 4) % 4);
            for (int k = 0; k < 4; k++) fb[k] = 8'(v + k);
            send_frame(4, 1'b1);
            wait_rise(c);
            check(c == w + 1, "R3", $sformatf("sweep wait v=%0d", v), c, w + 1);
            full_frame("R5 R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule